// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns a double-width product. It does not add the multiplicand once for every set bit of the multiplier. Each run of ones in the multiplier is recoded instead. The multiplicand is subtracted where a run begins and added back one position above where the run ends. Positions inside a run and positions between runs cost nothing. One shared add/subtract unit works on the upper half of a combined accumulator/multiplier register. That register shifts right arithmetically once per iteration.

A caller pulses `start` for one cycle while `busy` is low, with both operands on the inputs. The block then runs exactly `OP_W` iterations, pulses `done` for one cycle, and drops `busy`. The product stays on `product` until the next accepted start.

The control is a three-state machine:
- `ST_IDLE` waits. In this state `start` loads the operands and moves the machine to `ST_STEP`.
- `ST_STEP` performs one recode/add/shift iteration per cycle. On the last iteration it moves to `ST_DONE`.
- `ST_DONE` raises `done` for one cycle and always returns to `ST_IDLE`.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` high in a cycle where `busy` is 0 is accepted. `busy` is 1 in the following cycle and `done` is 0 in that cycle.
- R3: Once `done` is seen, `product` equals the signed product of the two operands taken at the accepted start, sign-extended to 2*OP_W bits.
- R4: The recoding uses the pair (current multiplier bit, previously examined bit), and the previous bit starts at 0. The pair 1,0 subtracts the multiplicand and 0,1 adds it. The pairs 0,0 and 1,1 leave the accumulator unchanged. As a result, multipliers made of runs of ones, alternating bits or all ones give the exact product.
- R5: `done` is high exactly OP_W+1 cycles after the start is accepted, that is, after OP_W iteration cycles.
- R6: `done` is high for one cycle only. `busy` is high in that cycle and low in the next.
- R7: `product` holds its value from the `done` cycle until the next accepted start, whatever the operand inputs do.
- R8: A `start` while `busy` is 1, including in the `done` cycle, is ignored. It changes neither the result nor the latency, and `busy` stays 1 until `done`.
- R9: The most negative operand gives exact results: times -1, times itself, and times the most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a multiply |
| mcand_i | input | OP_W | Signed multiplicand, sampled at an accepted start |
| mplier_i | input | OP_W | Signed multiplier, sampled at an accepted start |
| busy | output | 1 | High from the cycle after an accepted start up to and including the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*OP_W | Signed product |

## Verification
The table vectors each aim at one part of the recoding:
- 6 times m has a single inner run of ones, so one subtraction and one addition are enough.
- An all-ones multiplier uses only the subtract at bit 0, which tests that the previous bit starts at 0.
- Alternating bits force an add or a subtract at every position.
- Zero operands must give a zero product.

The most-negative cases expose a missing guard bit in the upper-half adder. Random signed pairs cover mixed sign combinations. Directed runs check the latency, the done pulse, a start during the run and in the done cycle, and that the product holds while the inputs change.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } booth_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } booth_act_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic       cur_bit,
    input  logic       prev_bit,
    output booth_act_e act
);
    // Entering a run of ones subtracts; leaving it adds back.
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   act = ACT_SUB;
            2'b01:   act = ACT_ADD;
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int OP_W = 32,
    localparam int ACC_W = OP_W + 1
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [OP_W-1:0]  mcand,
    input  booth_act_e       act,
    output logic [ACC_W-1:0] sum
);
    logic [ACC_W-1:0] mc_ext;
    assign mc_ext = {mcand[OP_W-1], mcand};

    always_comb begin
        unique case (act)
            ACT_ADD: sum = acc + mc_ext;
            ACT_SUB: sum = acc - mc_ext;
            default: sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_iter_cnt.sv
module booth_iter_cnt #(
    parameter int OP_W = 32,
    localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(OP_W - 1));
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int OP_W = 32,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = OP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] product
);
    booth_state_e state_q, state_d;

    logic [ACC_W-1:0] acc_q;
    logic [OP_W-1:0]  mq_q;
    logic             prev_q;
    logic [OP_W-1:0]  mc_q;

    logic             load;
    logic             step;
    logic             last_iter;
    booth_act_e       act;
    logic [ACC_W-1:0] sum;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_STEP;
            ST_STEP: if (last_iter) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_STEP: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    booth_iter_cnt #(.OP_W(OP_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .inc   (step),
        .last  (last_iter)
    );

    booth_recode u_recode (
        .cur_bit  (mq_q[0]),
        .prev_bit (prev_q),
        .act      (act)
    );

    booth_addsub #(.OP_W(OP_W)) u_addsub (
        .acc   (acc_q),
        .mcand (mc_q),
        .act   (act),
        .sum   (sum)
    );

    // Combined register {acc, mq} shifts right arithmetically each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mq_q   <= '0;
            prev_q <= 1'b0;
            mc_q   <= '0;
        end else if (load) begin
            acc_q  <= '0;
            mq_q   <= mplier_i;
            prev_q <= 1'b0;
            mc_q   <= mcand_i;
        end else if (step) begin
            acc_q  <= {sum[ACC_W-1], sum[ACC_W-1:1]};
            mq_q   <= {sum[0], mq_q[OP_W-1:1]};
            prev_q <= mq_q[0];
        end
    end

    assign product = {acc_q[OP_W-1:0], mq_q};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int OP_W = 32,
    localparam int PROD_W = 2 * OP_W,
    localparam int RC_W = $clog2(OP_W + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [PROD_W-1:0] product
);
    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_cnt <= '0;
        end else if (!done) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == RC_W'(OP_W)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(product));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind booth_seq_mul booth_mul_chk #(.OP_W(OP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W = 32;
    localparam int PROD_W = 2 * OP_W;
    localparam int NVEC = 10;

    // {multiplicand, multiplier, expected product}
    localparam logic [127:0] VECS [NVEC] = '{
        {32'd6,        32'd7,        64'd42},
        {32'd7,        32'd6,        64'd42},
        {32'd6,        32'hFFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFE2},
        {32'h0000_1234, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_EDCC},
        {32'h0000_0003, 32'h5555_5555, 64'h0000_0000_FFFF_FFFF},
        {32'd0,        32'h8000_0000, 64'd0},
        {32'h8000_0000, 32'hFFFF_FFFF, 64'h0000_0000_8000_0000},
        {32'h8000_0000, 32'h8000_0000, 64'h4000_0000_0000_0000},
        {32'h8000_0000, 32'h7FFF_FFFF, 64'hC000_0000_8000_0000},
        {32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'h3FFF_FFFF_0000_0001}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [OP_W-1:0]   mcand_i = '0;
    logic [OP_W-1:0]   mplier_i = '0;
    logic              busy;
    logic              done;
    logic [PROD_W-1:0] product;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_seq_mul #(.OP_W(OP_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] smul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        logic signed [63:0] sa, sb;
        sa = 64'(signed'(a));
        sb = 64'(signed'(b));
        return 64'(sa * sb);
    endfunction

    // Start a multiply at a negedge, wait for done; returns the product and latency.
    // When mid_at > 0, a competing start is pulsed at that cycle of the run.
    task automatic run_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                           input int mid_at,
                           output logic [63:0] res, output int lat);
        @(negedge clk);
        mcand_i = a;
        mplier_i = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check64("R2 busy after start", 64'(busy), 64'd1);
        lat = 0;
        do begin
            if (mid_at > 0 && lat == mid_at) begin
                mcand_i = 32'h0000_0005;
                mplier_i = 32'h0000_0009;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 1000);
        res = product;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] res;
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check64("R1 busy", 64'(busy), 64'd0);
        check64("R1 done", 64'(done), 64'd0);
        check64("R1 product", product, 64'd0);
        rst_n = 1'b1;

        // Table of vectors: R3, R4, R9
        for (int i = 0; i < NVEC; i++) begin
            run_mul(VECS[i][127:96], VECS[i][95:64], 0, res, lat);
            check64("R3 R4 R9 table product", res, VECS[i][63:0]);
            check64("R5 latency", 64'(lat), 64'(OP_W));
        end

        // R3 random signed pairs
        for (int i = 0; i < 20; i++) begin
            logic [OP_W-1:0] a, b;
            a = $urandom;
            b = $urandom;
            run_mul(a, b, 0, res, lat);
            check64("R3 random product", res, smul(a, b));
        end

        // R6 done one cycle, then R7 hold while inputs change, R8 start in done cycle
        run_mul(32'hFFFF_FF9C, 32'd300, 0, res, lat);
        check64("R6 done in busy", 64'(busy), 64'd1);
        mcand_i = 32'h1111_1111;
        mplier_i = 32'h2222_2222;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check64("R6 done falls", 64'(done), 64'd0);
        check64("R8 start in done ignored", 64'(busy), 64'd0);
        repeat (5) begin
            mcand_i = $urandom;
            mplier_i = $urandom;
            @(negedge clk);
        end
        check64("R7 product held", product, 64'hFFFF_FFFF_FFFF_8AD0);

        // R8 start mid-run ignored
        run_mul(32'hFFFF_FFF9, 32'd13, 10, res, lat);
        check64("R8 mid-run start result", res, 64'hFFFF_FFFF_FFFF_FFA5);
        check64("R8 mid-run start latency", 64'(lat), 64'(OP_W));
        @(negedge clk);
        check64("R8 idle after run", 64'(busy), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule